// File: doc/BRIEF.md
# Index-Register Test-and-Branch Unit

This block holds a small bank of 15-bit index registers and carries out the loop-control branches that test and update them. Each cycle it can take one decoded 36-bit instruction word. The word holds a prefix in bits 35:33, a decrement in bits 32:18, a tag in bits 17:15 and an address in bits 14:0. From that word the block decides whether a branch is taken and writes any register update.

The tag selects index registers in one of two modes. In seven-register mode, each nonzero tag value names a single register. In three-register mode, each tag bit names a register, and the registers it names are ORed together. The ORed value is also the index contribution that other instructions add to their addresses.

Besides the five prefixed branches, two operations ride on prefix 000. The first stores the negated instruction location, as a subroutine call does. The second writes the ORed value back into every selected register. Branch outputs are combinational with the valid strobe. Register writes land on the clock edge where the strobe is high.

Top module: `xreg_branch_unit`

## Requirements
- R1: Tag 000 selects no register: `index_value` reads 0 and no register is written, though a prefix that always branches still branches.
- R2: With `mode_seven` low, tag bits 0, 1 and 2 select XR1, XR2 and XR4. `index_value` is the OR of every selected register, and any update is written into all of them.
- R3: With `mode_seven` high, a nonzero tag t selects XRt alone, and no other register is read or written.
- R4: Prefix 001 writes (XR + decrement) mod 2^15 into the selection and is always taken.
- R5: Prefix 010 is taken and writes XR − decrement when XR > decrement (unsigned). Otherwise it is not taken and writes nothing.
- R6: Prefix 110 writes XR − decrement and is not taken when XR > decrement. Otherwise it is taken and writes nothing.
- R7: Prefix 011 is taken exactly when XR > decrement, and prefix 111 is taken exactly when XR ≤ decrement. Neither writes a register.
- R8: Prefix 000 with `bop` = 01 writes (2^15 − `instr_loc`) mod 2^15 into the selection and is taken.
- R9: Prefix 000 with `bop` = 10 writes the ORed selection back into every selected register and is not taken.
- R10: With `instr_valid` low, and for prefixes 100 and 101, and for prefix 000 with `bop` 00 or 11, no register changes and `branch_taken` is low.
- R11: Synchronous reset clears all registers to 0. `branch_target` always equals instruction bits 14:0.
- R12: `xr_all` bits [15k−1:15(k−1)] show XRk for k = 1..7, and a write is visible there after the clock edge on which it was strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction strobe |
| instr_word | input | 36 | Decoded instruction: prefix, decrement, tag, address |
| mode_seven | input | 1 | 1 = seven-register mode, 0 = three-register OR mode |
| bop | input | 2 | Operation on prefix 000: 00 none, 01 set index, 10 merge |
| instr_loc | input | 15 | Location of the current instruction |
| branch_taken | output | 1 | Branch decision for the strobed instruction |
| branch_target | output | 15 | Branch destination (address field) |
| index_value | output | 15 | OR of selected registers, pre-update |
| xr_all | output | 105 | All seven index registers, XR1 in the low bits |

## Verification
The bench targets the boundary where register and decrement are equal. A design that treats a zero difference as positive would branch on prefix 010, would fail to branch on 110, and would write a zero into the register. The bench also wraps the add past 2^15 and negates a location for the set-index operation; a design with an off-by-one complement would leave the register one too high. In three-register mode it checks that a combined tag ORs XR1, XR2 and XR4 and writes every selected register. A design that used only the lowest tag bit, or that mapped tag bit 2 to XR3, would leave registers stale. Tag zero and a cleared valid strobe must leave the whole bank untouched.

// File: rtl/xrb_pkg.sv
package xrb_pkg;
    localparam int XW  = 15;
    localparam int TW  = 3;
    localparam int PW  = 3;
    localparam int NXR = (1 << TW) - 1;
    localparam int IW  = PW + XW + TW + XW;

    typedef logic [XW-1:0] xval_t;

    typedef enum logic [PW-1:0] {
        PF_TYPEB = 3'b000,
        PF_INCJ  = 3'b001,
        PF_DECJ  = 3'b010,
        PF_HIGH  = 3'b011,
        PF_RSV4  = 3'b100,
        PF_RSV5  = 3'b101,
        PF_DECN  = 3'b110,
        PF_LOWE  = 3'b111
    } prefix_e;

    typedef enum logic [1:0] {
        BOP_NONE  = 2'b00,
        BOP_SETX  = 2'b01,
        BOP_MERGE = 2'b10,
        BOP_RSV   = 2'b11
    } bop_e;

    typedef struct packed {
        prefix_e        prefix;
        xval_t          decr;
        logic [TW-1:0]  tag;
        xval_t          addr;
    } instr_t;

    typedef struct packed {
        logic  taken;
        logic  wr_en;
        xval_t wr_data;
    } xact_t;

    function automatic logic [NXR:1] tag_mask(input logic [TW-1:0] tag, input logic seven);
        logic [NXR:1] m;
        m = '0;
        for (int k = 1; k <= NXR; k++) begin
            if (seven)
                m[k] = (int'(tag) == k);
            else
                m[k] = ((k & (k - 1)) == 0) && ((k & int'(tag)) != 0);
        end
        return m;
    endfunction
endpackage

// File: rtl/xrb_tag_decode.sv
module xrb_tag_decode
    import xrb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] tag,
    input  logic          seven,
    output logic [NXR:1]  mask
);
    assign mask = tag_mask(tag, seven);

    // R3: seven-register mode never selects more than one register
    a_r3_single_select: assert property (@(posedge clk) disable iff (rst)
        seven |-> $onehot0(mask));

    // R1: tag zero selects nothing in either mode
    a_r1_empty_select: assert property (@(posedge clk) disable iff (rst)
        (tag == '0) |-> (mask == '0));

    // R2: three-register mode never touches XR3, XR5, XR6, XR7
    a_r2_power_slots: assert property (@(posedge clk) disable iff (rst)
        !seven |-> (mask[3] == 1'b0 && mask[5] == 1'b0 && mask[6] == 1'b0 && mask[7] == 1'b0));
endmodule

// File: rtl/xrb_read_or.sv
module xrb_read_or
    import xrb_pkg::*;
(
    input  xval_t         regs [1:NXR],
    input  logic [NXR:1]  mask,
    output xval_t         val
);
    always_comb begin
        val = '0;
        for (int k = 1; k <= NXR; k++) begin
            if (mask[k])
                val = val | regs[k];
        end
    end
endmodule

// File: rtl/xrb_branch_eval.sv
module xrb_branch_eval
    import xrb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   valid,
    input  instr_t ins,
    input  bop_e   op,
    input  xval_t  loc,
    input  xval_t  xv,
    output xact_t  act
);
    logic  above;
    xval_t diff;
    xval_t sum;
    xval_t neg_loc;

    assign above   = (xv > ins.decr);
    assign diff    = xv - ins.decr;
    assign sum     = xv + ins.decr;
    assign neg_loc = ~loc + 1'b1;

    always_comb begin
        act = '0;
        if (valid) begin
            unique case (ins.prefix)
                PF_INCJ: begin
                    act.taken   = 1'b1;
                    act.wr_en   = 1'b1;
                    act.wr_data = sum;
                end
                PF_DECJ: begin
                    act.taken   = above;
                    act.wr_en   = above;
                    act.wr_data = diff;
                end
                PF_DECN: begin
                    act.taken   = !above;
                    act.wr_en   = above;
                    act.wr_data = diff;
                end
                PF_HIGH: act.taken = above;
                PF_LOWE: act.taken = !above;
                PF_TYPEB: begin
                    unique case (op)
                        BOP_SETX: begin
                            act.taken   = 1'b1;
                            act.wr_en   = 1'b1;
                            act.wr_data = neg_loc;
                        end
                        BOP_MERGE: begin
                            act.wr_en   = 1'b1;
                            act.wr_data = xv;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // R4: the increment branch is unconditional
    a_r4_inc_always: assert property (@(posedge clk) disable iff (rst)
        (valid && ins.prefix == PF_INCJ) |-> act.taken);

    // R5: a taken decrement branch never leaves zero behind
    a_r5_positive_result: assert property (@(posedge clk) disable iff (rst)
        (valid && ins.prefix == PF_DECJ && act.taken) |-> (act.wr_data != '0 && act.wr_en));

    // R6: the no-index branch writes or branches, never both
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        (valid && ins.prefix == PF_DECN) |-> (act.taken != act.wr_en));

    // R7: the compare branches never write
    a_r7_compare_nowrite: assert property (@(posedge clk) disable iff (rst)
        (valid && (ins.prefix == PF_HIGH || ins.prefix == PF_LOWE)) |-> !act.wr_en);

    // R10: nothing happens without the strobe
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (!act.taken && !act.wr_en));
endmodule

// File: rtl/xreg_branch_unit.sv
module xreg_branch_unit
    import xrb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [IW-1:0]     instr_word,
    input  logic              mode_seven,
    input  logic [1:0]        bop,
    input  logic [XW-1:0]     instr_loc,
    output logic              branch_taken,
    output logic [XW-1:0]     branch_target,
    output logic [XW-1:0]     index_value,
    output logic [NXR*XW-1:0] xr_all
);
    instr_t       ins;
    logic [NXR:1] mask;
    xval_t        xr_q [1:NXR];
    xval_t        xv;
    xact_t        act;

    assign ins = instr_t'(instr_word);

    xrb_tag_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .tag   (ins.tag),
        .seven (mode_seven),
        .mask  (mask)
    );

    xrb_read_or u_rd (
        .regs (xr_q),
        .mask (mask),
        .val  (xv)
    );

    xrb_branch_eval u_ev (
        .clk   (clk),
        .rst   (rst),
        .valid (instr_valid),
        .ins   (ins),
        .op    (bop_e'(bop)),
        .loc   (instr_loc),
        .xv    (xv),
        .act   (act)
    );

    for (genvar k = 1; k <= NXR; k++) begin : g_xr
        always_ff @(posedge clk) begin
            if (rst)
                xr_q[k] <= '0;
            else if (act.wr_en && mask[k])
                xr_q[k] <= act.wr_data;
        end
        assign xr_all[k*XW-1 -: XW] = xr_q[k];
    end

    assign branch_taken  = act.taken;
    assign branch_target = ins.addr;
    assign index_value   = xv;

    // R10: the bank holds whenever no instruction is strobed
    a_r10_bank_hold: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(xr_all));

    // R1: tag zero contributes nothing to the index
    a_r1_zero_index: assert property (@(posedge clk) disable iff (rst)
        (ins.tag == '0) |-> (index_value == '0));

    // R3: in seven-register mode an instruction not naming XR1 leaves it alone
    a_r3_xr1_untouched: assert property (@(posedge clk) disable iff (rst)
        (mode_seven && ins.tag != 3'd1) |=> (xr_q[1] == $past(xr_q[1])));

    // R11: target follows the address field
    a_r11_target: assert property (@(posedge clk) disable iff (rst)
        branch_target == instr_word[XW-1:0]);
endmodule

// File: tb/sim_xreg_branch_unit.sv
module sim_xreg_branch_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         instr_valid;
    logic [35:0]  instr_word;
    logic         mode_seven;
    logic [1:0]   bop;
    logic [14:0]  instr_loc;
    logic         branch_taken;
    logic [14:0]  branch_target;
    logic [14:0]  index_value;
    logic [104:0] xr_all;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic        s_taken;
    logic [14:0] s_target;
    logic [14:0] s_index;

    always #4 clk = ~clk;

    xreg_branch_unit u0 (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .mode_seven(mode_seven), .bop(bop), .instr_loc(instr_loc),
        .branch_taken(branch_taken), .branch_target(branch_target),
        .index_value(index_value), .xr_all(xr_all)
    );

    function automatic logic [14:0] xr(input int k);
        return xr_all[k*15-1 -: 15];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input bit seven, input logic [2:0] pf, input int dec,
                         input int tag, input int addr, input int loc,
                         input logic [1:0] op, input bit vld);
        @(negedge clk);
        instr_valid = vld;
        mode_seven  = seven;
        bop         = op;
        instr_loc   = loc[14:0];
        instr_word  = {pf, dec[14:0], tag[2:0], addr[14:0]};
        #2;
        s_taken  = branch_taken;
        s_target = branch_target;
        s_index  = index_value;
        @(posedge clk);
        #1;
        instr_valid = 1'b0;
    endtask

    task automatic load(input int k, input int v);
        issue(1, 3'b000, 0, k, 0, (32768 - v) % 32768, 2'b01, 1);
    endtask

    task automatic t_reset;
        for (int k = 1; k <= 7; k++) chk("R11 reset clear", xr(k), 0);
        chk("R10 idle not taken", branch_taken, 0);
    endtask

    task automatic t_setx;
        issue(1, 3'b000, 0, 3, 15'h1ABC, 32668, 2'b01, 1);
        chk("R8 set index taken", s_taken, 1);
        chk("R11 target", s_target, 15'h1ABC);
        chk("R8 negated location", xr(3), 100);
        chk("R12 other slot", xr(2), 0);
    endtask

    task automatic t_seven;
        load(5, 15'h1234);
        issue(1, 3'b000, 0, 5, 0, 0, 2'b00, 1);
        chk("R3 read XR5", s_index, 15'h1234);
        issue(1, 3'b000, 0, 3, 0, 0, 2'b00, 1);
        chk("R3 read XR3", s_index, 100);
        issue(1, 3'b001, 1, 5, 7, 0, 2'b00, 1);
        chk("R3 write XR5 only", xr(5), 15'h1235);
        chk("R3 XR3 untouched", xr(3), 100);
        chk("R3 XR4 untouched", xr(4), 0);
    endtask

    task automatic t_tag_zero;
        issue(1, 3'b000, 0, 0, 0, 0, 2'b00, 1);
        chk("R1 zero index", s_index, 0);
        issue(1, 3'b001, 5, 0, 15'h0200, 0, 2'b00, 1);
        chk("R1 increment still taken", s_taken, 1);
        chk("R1 XR3 unchanged", xr(3), 100);
        chk("R1 XR5 unchanged", xr(5), 15'h1235);
    endtask

    task automatic t_inc;
        issue(1, 3'b001, 32767, 3, 15'h0044, 0, 2'b00, 1);
        chk("R4 taken", s_taken, 1);
        chk("R4 wrap sum", xr(3), 99);
    endtask

    task automatic t_dec;
        issue(1, 3'b010, 40, 3, 15'h0050, 0, 2'b00, 1);
        chk("R5 positive taken", s_taken, 1);
        chk("R5 positive write", xr(3), 59);
        issue(1, 3'b010, 59, 3, 15'h0050, 0, 2'b00, 1);
        chk("R5 zero not taken", s_taken, 0);
        chk("R5 zero keeps", xr(3), 59);
        issue(1, 3'b010, 70, 3, 15'h0050, 0, 2'b00, 1);
        chk("R5 negative not taken", s_taken, 0);
        chk("R5 negative keeps", xr(3), 59);
    endtask

    task automatic t_decn;
        issue(1, 3'b110, 9, 3, 15'h0060, 0, 2'b00, 1);
        chk("R6 positive not taken", s_taken, 0);
        chk("R6 positive write", xr(3), 50);
        issue(1, 3'b110, 50, 3, 15'h0060, 0, 2'b00, 1);
        chk("R6 zero taken", s_taken, 1);
        chk("R6 zero keeps", xr(3), 50);
    endtask

    task automatic t_compare;
        issue(1, 3'b011, 49, 3, 1, 0, 2'b00, 1);
        chk("R7 high above", s_taken, 1);
        issue(1, 3'b011, 50, 3, 1, 0, 2'b00, 1);
        chk("R7 high equal", s_taken, 0);
        issue(1, 3'b111, 50, 3, 1, 0, 2'b00, 1);
        chk("R7 low-or-equal equal", s_taken, 1);
        issue(1, 3'b111, 49, 3, 1, 0, 2'b00, 1);
        chk("R7 low-or-equal above", s_taken, 0);
        chk("R7 no write", xr(3), 50);
    endtask

    task automatic t_three;
        load(1, 15'h0011);
        load(2, 15'h0300);
        load(4, 15'h4000);
        issue(0, 3'b000, 0, 3, 0, 0, 2'b00, 1);
        chk("R2 OR XR1 XR2", s_index, 15'h0311);
        issue(0, 3'b000, 0, 5, 0, 0, 2'b00, 1);
        chk("R2 OR XR1 XR4", s_index, 15'h4011);
        issue(0, 3'b001, 1, 3, 0, 0, 2'b00, 1);
        chk("R2 write XR1", xr(1), 15'h0312);
        chk("R2 write XR2", xr(2), 15'h0312);
        chk("R2 XR4 kept", xr(4), 15'h4000);
        chk("R2 XR3 kept", xr(3), 50);
    endtask

    task automatic t_merge;
        issue(0, 3'b000, 0, 6, 0, 0, 2'b10, 1);
        chk("R9 not taken", s_taken, 0);
        chk("R9 merge XR2", xr(2), 15'h4312);
        chk("R9 merge XR4", xr(4), 15'h4312);
        chk("R9 XR1 kept", xr(1), 15'h0312);
        issue(1, 3'b000, 0, 6, 0, 0, 2'b00, 1);
        chk("R3 XR6 separate", s_index, 0);
    endtask

    task automatic t_quiet;
        issue(1, 3'b001, 7, 3, 0, 0, 2'b00, 0);
        chk("R10 no strobe not taken", s_taken, 0);
        chk("R10 no strobe keeps", xr(3), 50);
        issue(1, 3'b100, 7, 3, 0, 0, 2'b00, 1);
        chk("R10 prefix 100 not taken", s_taken, 0);
        issue(1, 3'b101, 7, 3, 0, 0, 2'b00, 1);
        chk("R10 prefix 101 not taken", s_taken, 0);
        issue(1, 3'b000, 7, 3, 0, 0, 2'b11, 1);
        chk("R10 reserved op not taken", s_taken, 0);
        chk("R10 bank kept", xr(3), 50);
    endtask

    initial begin
        rst = 1'b1;
        instr_valid = 1'b0;
        instr_word = '0;
        mode_seven = 1'b1;
        bop = 2'b00;
        instr_loc = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset;
        t_setx;
        t_seven;
        t_tag_zero;
        t_inc;
        t_dec;
        t_decn;
        t_compare;
        t_three;
        t_merge;
        t_quiet;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule